// File: doc/BRIEF.md
# Banded Matrix-Vector Systolic Array

This block multiplies a banded square matrix by a vector with a straight chain of processing cells, one per diagonal of the band. The band has `LOWER` diagonals under the main diagonal and `UPPER` above it, so the chain holds `W = LOWER + UPPER + 1` cells. The operand vector moves down the chain in one direction and the partial row sums move the other way. Each token advances one cell per clock, and successive tokens are two clocks apart. Every cell adds the product of its matrix entry and the passing vector element to the passing partial sum. A single chain of `W` cells serves any row count up to `MAX_N`.

A batch is supplied one row per beat: the vector element of that row and the row's band entries. An internal sequencer stores the batch. It then plays the vector elements into the first cell and zero-valued sum tokens into the last cell. It also plays each band entry into its own diagonal's cell, timed so that the entry arrives together with the vector element and the partial sum it belongs to. Each finished row sum leaves the first cell with a strobe, and the final row is flagged.

Top module: `banded_mv_array`

## Requirements
- R1: While reset is held, and after reset until the first result, `out_valid` and `out_last` are low.
- R2: A batch is delivered as one beat per row while `in_valid` is high. The rows arrive in order, starting with row 1. In a beat for row i, `in_x` holds x_i and lane e of `in_band` (bits `[e*DW +: DW]`, e = 0..W-1) holds the entry at column i-LOWER+e. The row count n is the number of beats up to and including the one with `in_last` high.
- R3: When the MAX_N-th beat of a batch is accepted, the batch starts computing even if `in_last` is low.
- R4: Beats offered while a batch is computing are dropped. They change neither that batch's results nor the next batch's results.
- R5: Result i equals the signed sum of a(i,j)*x_j over the band columns j. The sum is exact in `ACC_W = 2*DW + clog2(W+1)` bits, including the most negative operands.
- R6: Band lanes whose column falls outside 1..n contribute nothing to any result.
- R7: The first result is valid in the cycle that starts max(UPPER-LOWER,0)+W rising edges after the edge that accepts the final beat.
- R8: Results come out in row order, each valid for exactly one cycle, with exactly two cycles from one result to the next.
- R9: `out_last` is high with the result of row n and at no other time.
- R10: Idle cycles between the beats of a batch change nothing. The next batch may begin in the cycle that carries the final result.
- R11: Each cell receives a valid matrix entry only in a cycle where a valid vector element and a valid partial sum also reach that cell. Vector elements enter the chain on alternate cycles at most.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Row beat present |
| in_last | input | 1 | This beat is the batch's final row |
| in_x | input | DW | Vector element of this row, signed |
| in_band | input | W*DW | Band entries of this row, lane e = column i-LOWER+e, signed |
| out_valid | output | 1 | Result strobe |
| out_last | output | 1 | Result belongs to the final row |
| out_y | output | ACC_W | Row result, signed |

## Verification
The corner that is hardest to reach from the ports is where a row's band runs past the edge of the matrix. In that case a partial sum meets either no vector element or a stale one left in the chain, and it must pass through unchanged. The stimulus places large nonzero values in every out-of-range lane and uses row counts of 1, 2, small, and the full `MAX_N`. Batches are also loaded back to back, so that vector tokens from the earlier batch are still moving through the chain when the new schedule begins. Beats offered during computation and gaps between load beats exercise the rules for which beats are accepted.

// File: rtl/banded_mv_pkg.sv
package banded_mv_pkg;

  typedef enum logic {
    SEQ_LOAD = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Cycles one stream must wait so the other stream can start at zero.
  function automatic int lead_of(input int a, input int b);
    return (a > b) ? (a - b) : 0;
  endfunction

endpackage

// File: rtl/banded_mv_seq.sv
module banded_mv_seq
  import banded_mv_pkg::*;
#(
  parameter int LOWER = 1,
  parameter int UPPER = 2,
  parameter int DW    = 8,
  parameter int MAX_N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_last,
  input  logic [DW-1:0]        in_x,
  input  logic [(LOWER+UPPER+1)*DW-1:0] in_band,
  output logic                 x_inj_vld,
  output logic [DW-1:0]        x_inj,
  output logic                 y_inj_vld,
  output logic                 y_inj_last,
  output logic [LOWER+UPPER:0] a_vld,
  output logic [(LOWER+UPPER+1)*DW-1:0] a_val
);

  localparam int W     = LOWER + UPPER + 1;
  localparam int X0    = lead_of(LOWER, UPPER);
  localparam int Y0    = lead_of(UPPER, LOWER);
  localparam int AW    = (MAX_N > 2) ? $clog2(MAX_N) : 1;
  localparam int NW    = $clog2(MAX_N + 1);
  localparam int T_MAX = Y0 + 2 * (MAX_N - 1) + W;
  localparam int TW    = $clog2(T_MAX + 1);

  seq_state_e          state;
  logic [AW-1:0]       cnt;
  logic [NW-1:0]       n_rows;
  logic [TW-1:0]       t;
  logic [TW-1:0]       t_stop;
  logic                run;
  logic                take;
  logic [DW-1:0]       x_mem    [MAX_N];
  logic [DW-1:0]       band_mem [MAX_N][W];

  assign run    = (state == SEQ_RUN);
  assign take   = (state == SEQ_LOAD) && in_valid;
  // Last cycle of the run: the cycle before row n's sum reaches the output.
  assign t_stop = TW'(Y0 + W - 1) + (TW'(n_rows) << 1) - TW'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_LOAD;
      cnt    <= '0;
      n_rows <= '0;
      t      <= '0;
    end else if (state == SEQ_LOAD) begin
      if (in_valid) begin
        cnt <= cnt + AW'(1);
        if (in_last || (cnt == AW'(MAX_N - 1))) begin
          n_rows <= NW'(cnt) + NW'(1);
          cnt    <= '0;
          t      <= '0;
          state  <= SEQ_RUN;
        end
      end
    end else begin
      t <= t + TW'(1);
      if (t == t_stop) state <= SEQ_LOAD;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      x_mem[cnt] <= in_x;
      for (int e = 0; e < W; e++) band_mem[cnt][e] <= in_band[e*DW +: DW];
    end
  end

  // Schedule: x_j reaches cell k at 2(j-1)+k+X0, the zero sum of row i
  // enters the far cell at 2(i-1)+Y0, so cell k meets column j = i+UPPER-k.
  always_comb begin
    int r;
    int jx;
    int iy;
    r          = int'(t) - X0;
    x_inj_vld  = run && (r >= 0) && (r % 2 == 0) && ((r / 2) < int'(n_rows));
    x_inj      = x_inj_vld ? x_mem[AW'(r / 2)] : '0;
    r          = int'(t) - Y0;
    y_inj_vld  = run && (r >= 0) && (r % 2 == 0) && ((r / 2) < int'(n_rows));
    y_inj_last = y_inj_vld && ((r / 2) == int'(n_rows) - 1);
    for (int k = 0; k < W; k++) begin
      r  = int'(t) - k - X0;
      jx = r / 2;
      iy = jx + k - UPPER;
      a_vld[k] = run && (r >= 0) && (r % 2 == 0) && (jx < int'(n_rows))
                 && (iy >= 0) && (iy < int'(n_rows));
      a_val[k*DW +: DW] = a_vld[k] ? band_mem[AW'(iy)][W-1-k] : '0;
    end
  end

endmodule

// File: rtl/banded_mv_cell.sv
module banded_mv_cell #(
  parameter int DW    = 8,
  parameter int ACC_W = 19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    x_in_vld,
  input  logic signed [DW-1:0]    x_in,
  input  logic                    a_in_vld,
  input  logic signed [DW-1:0]    a_in,
  input  logic                    y_in_vld,
  input  logic                    y_in_last,
  input  logic signed [ACC_W-1:0] y_in,
  output logic                    x_out_vld,
  output logic signed [DW-1:0]    x_out,
  output logic                    y_out_vld,
  output logic                    y_out_last,
  output logic signed [ACC_W-1:0] y_out
);

  // One multiply-accumulate step; an empty matrix slot adds nothing.
  function automatic logic signed [ACC_W-1:0] mac_step(
    input logic signed [ACC_W-1:0] acc,
    input logic signed [DW-1:0]    a,
    input logic signed [DW-1:0]    x,
    input logic                    use_a
  );
    logic signed [ACC_W-1:0] prod;
    prod = ACC_W'(a) * ACC_W'(x);
    return use_a ? acc + prod : acc;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_out_vld  <= 1'b0;
      x_out      <= '0;
      y_out_vld  <= 1'b0;
      y_out_last <= 1'b0;
      y_out      <= '0;
    end else begin
      x_out_vld  <= x_in_vld;
      x_out      <= x_in;
      y_out_vld  <= y_in_vld;
      y_out_last <= y_in_vld && y_in_last;
      y_out      <= mac_step(y_in, a_in, x_in, a_in_vld);
    end
  end

endmodule

// File: rtl/banded_mv_array.sv
module banded_mv_array #(
  parameter  int LOWER = 1,
  parameter  int UPPER = 2,
  parameter  int DW    = 8,
  parameter  int MAX_N = 16,
  localparam int W     = LOWER + UPPER + 1,
  localparam int ACC_W = 2 * DW + $clog2(W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_last,
  input  logic [DW-1:0]           in_x,
  input  logic [W*DW-1:0]         in_band,
  output logic                    out_valid,
  output logic                    out_last,
  output logic signed [ACC_W-1:0] out_y
);

  logic                    x_inj_vld;
  logic [DW-1:0]           x_inj;
  logic                    y_inj_vld;
  logic                    y_inj_last;
  logic [W-1:0]            a_vld;
  logic [W*DW-1:0]         a_val;

  // Tokens on each cell's inputs, named for the checker.
  logic [W-1:0]            x_at_vld;
  logic [W-1:0]            y_at_vld;
  logic [W-1:0]            y_at_last;
  logic signed [DW-1:0]    x_at [W];
  logic signed [ACC_W-1:0] y_at [W];

  // Registered cell outputs.
  logic [W-1:0]            x_q_vld;
  logic [W-1:0]            y_q_vld;
  logic [W-1:0]            y_q_last;
  logic signed [DW-1:0]    x_q [W];
  logic signed [ACC_W-1:0] y_q [W];

  banded_mv_seq #(
    .LOWER(LOWER), .UPPER(UPPER), .DW(DW), .MAX_N(MAX_N)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_x      (in_x),
    .in_band   (in_band),
    .x_inj_vld (x_inj_vld),
    .x_inj     (x_inj),
    .y_inj_vld (y_inj_vld),
    .y_inj_last(y_inj_last),
    .a_vld     (a_vld),
    .a_val     (a_val)
  );

  for (genvar k = 0; k < W; k++) begin : g_cell
    if (k == 0) begin : g_xhead
      assign x_at_vld[k] = x_inj_vld;
      assign x_at[k]     = x_inj;
    end else begin : g_xlink
      assign x_at_vld[k] = x_q_vld[k-1];
      assign x_at[k]     = x_q[k-1];
    end
    if (k == W - 1) begin : g_yhead
      assign y_at_vld[k]  = y_inj_vld;
      assign y_at_last[k] = y_inj_last;
      assign y_at[k]      = '0;
    end else begin : g_ylink
      assign y_at_vld[k]  = y_q_vld[k+1];
      assign y_at_last[k] = y_q_last[k+1];
      assign y_at[k]      = y_q[k+1];
    end

    banded_mv_cell #(.DW(DW), .ACC_W(ACC_W)) i_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .x_in_vld  (x_at_vld[k]),
      .x_in      (x_at[k]),
      .a_in_vld  (a_vld[k]),
      .a_in      (a_val[k*DW +: DW]),
      .y_in_vld  (y_at_vld[k]),
      .y_in_last (y_at_last[k]),
      .y_in      (y_at[k]),
      .x_out_vld (x_q_vld[k]),
      .x_out     (x_q[k]),
      .y_out_vld (y_q_vld[k]),
      .y_out_last(y_q_last[k]),
      .y_out     (y_q[k])
    );
  end

  assign out_valid = y_q_vld[0];
  assign out_last  = y_q_last[0];
  assign out_y     = y_q[0];

endmodule

// File: rtl/banded_mv_chk.sv
module banded_mv_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         out_valid,
  input logic         out_last,
  input logic         x_inj_vld,
  input logic [W-1:0] x_at_vld,
  input logic [W-1:0] y_at_vld,
  input logic [W-1:0] a_vld
);

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid && !out_last);

  // R8
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R8
  cadence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |=> ##1 out_valid);

  // R9
  last_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R11
  entry_meets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_vld & ~(x_at_vld & y_at_vld)) == '0);

  // R11
  x_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    x_inj_vld |=> !x_inj_vld);

endmodule

bind banded_mv_array banded_mv_chk #(.W(W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .out_valid(out_valid),
  .out_last (out_last),
  .x_inj_vld(x_inj_vld),
  .x_at_vld (x_at_vld),
  .y_at_vld (y_at_vld),
  .a_vld    (a_vld)
);

// File: tb/test_banded_mv_array.sv
`timescale 1ns/1ps
module test_banded_mv_array;

  localparam int LOWER = 1;
  localparam int UPPER = 2;
  localparam int DW    = 8;
  localparam int MAX_N = 16;
  localparam int W     = LOWER + UPPER + 1;
  localparam int ACC_W = 2 * DW + $clog2(W + 1);
  localparam int LEAD  = (UPPER > LOWER) ? UPPER - LOWER : 0;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    in_valid = 1'b0;
  logic                    in_last = 1'b0;
  logic [DW-1:0]           in_x = '0;
  logic [W*DW-1:0]         in_band = '0;
  logic                    out_valid;
  logic                    out_last;
  logic signed [ACC_W-1:0] out_y;

  banded_mv_array #(.LOWER(LOWER), .UPPER(UPPER), .DW(DW), .MAX_N(MAX_N))
    i_banded_mv_array (.*);

  always #2.5 clk = ~clk;

  typedef struct {int cyc; longint val; bit last; int row;} exp_t;
  exp_t exp_q[$];

  int  cyc = 0;
  int  tests = 0;
  int  fails = 0;
  bit  done = 1'b0;
  bit  live = 1'b0;
  int  xs [MAX_N];
  int  bd [MAX_N][W];

  always @(posedge clk) cyc <= cyc + 1;

  // Reference comparison on every cycle once reset is released.
  always @(negedge clk) begin
    if (live && !done) begin
      tests++;
      if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
        // R5/R6/R7/R9/R11
        if (!out_valid || longint'(out_y) != exp_q[0].val || out_last != exp_q[0].last) begin
          fails++;
          $display("FAIL R5/R7/R9 row %0d: valid=%0b y=%0d last=%0b expected valid=1 y=%0d last=%0b",
                   exp_q[0].row, out_valid, out_y, out_last, exp_q[0].val, exp_q[0].last);
        end
        void'(exp_q.pop_front());
      end else if (out_valid || out_last) begin
        // R8: no strobe outside the expected result cycles
        fails++;
        $display("FAIL R8 cycle %0d: valid=%0b last=%0b expected valid=0 last=0",
                 cyc, out_valid, out_last);
      end
    end
  end

  function automatic int pick(input int mode);
    case (mode)
      1:       return ($urandom_range(0, 1) == 1) ? -128 : 127;
      2:       return -128;
      default: return int'($urandom_range(0, 40)) - 20;
    endcase
  endfunction

  task automatic drive_row(input int r, input bit last);
    @(negedge clk);
    in_valid = 1'b1;
    in_last  = last;
    in_x     = DW'(xs[r]);
    for (int e = 0; e < W; e++) in_band[e*DW +: DW] = DW'(bd[r][e]);
  endtask

  // R2/R3/R4/R10 batch driver; reference sums computed from the rows.
  task automatic run_batch(input int n, input bit with_last, input int mode,
                           input bit gaps, input bit junk);
    int acc;
    acc = 0;
    for (int r = 0; r < n; r++) begin
      xs[r] = pick(mode);
      // R6: lanes off the matrix carry large values that must not count
      for (int e = 0; e < W; e++) bd[r][e] = pick(mode);
    end
    for (int r = 0; r < n; r++) begin
      if (gaps && (r % 2 == 1)) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_x     = DW'(99);
      end
      drive_row(r, with_last && (r == n - 1));
      if (r == n - 1) acc = cyc + 1;
    end
    for (int i = 0; i < n; i++) begin
      exp_t ex;
      longint s;
      s = 0;
      for (int e = 0; e < W; e++) begin
        int col;
        col = i - LOWER + e;
        if (col >= 0 && col < n) s += longint'(bd[i][e]) * longint'(xs[col]);
      end
      ex.cyc  = acc + LEAD + W + 2 * i;
      ex.val  = s;
      ex.last = (i == n - 1);
      ex.row  = i + 1;
      exp_q.push_back(ex);
    end
    if (junk) begin
      // R4: these beats land while the batch computes and must be dropped
      for (int g = 0; g < 3; g++) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_last  = (g == 1);
        in_x     = DW'($urandom_range(0, 255));
        in_band  = W*DW'($urandom);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    while (exp_q.size() > 0 && !done) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (4) begin
      @(negedge clk);
      tests++;
      // R1: quiet during reset
      if (out_valid || out_last) begin
        fails++;
        $display("FAIL R1 in reset: valid=%0b last=%0b expected 0 0", out_valid, out_last);
      end
    end
    rst_n = 1'b1;
    live  = 1'b1;
    repeat (3) @(negedge clk);

    run_batch(5, 1'b1, 0, 1'b0, 1'b0);          // R2/R5/R6 small batch
    run_batch(1, 1'b1, 0, 1'b0, 1'b0);          // R6 single row: only the diagonal
    run_batch(2, 1'b1, 1, 1'b0, 1'b0);          // R5 extreme values, two rows
    run_batch(8, 1'b1, 2, 1'b0, 1'b0);          // R5 all most-negative operands
    run_batch(6, 1'b1, 0, 1'b1, 1'b0);          // R10 gaps between beats
    run_batch(4, 1'b1, 0, 1'b0, 1'b1);          // R4 beats during computation
    run_batch(3, 1'b1, 0, 1'b0, 1'b0);          // R4 next batch unaffected, R10 back to back
    run_batch(MAX_N, 1'b0, 0, 1'b0, 1'b0);      // R3 full batch without last flag
    run_batch(MAX_N, 1'b1, 1, 1'b1, 1'b1);      // R3/R4/R5 full batch, extremes
    run_batch(7, 1'b1, 0, 1'b0, 1'b0);          // R7/R8/R9 after a full batch
    repeat (10) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

endmodule